// File: doc/BRIEF.md
# Shared-Buffer SPI Master

This block is a memory-mapped SPI master that moves up to a full buffer of bytes per transfer. Software writes the outgoing bytes into one byte buffer, then writes a 16-bit control word. That word carries the byte count, a start bit, an interrupt enable and a flag that releases chip select at the end. The shift engine sends the bytes from buffer offset 0 upward, most significant bit first, in SPI mode 0. Each received byte overwrites the byte it replaced, so when the transfer ends the buffer holds the read data.

Chip select is asserted when a transfer starts. It is released after the final byte only if the release flag was part of the start command. Software can therefore chain several buffer-sized fragments into one long chip-select frame, and close that frame at the end of the last fragment. A control write that sets the release flag without the start bit closes the frame at once. A completion flag is set when a transfer finishes and is cleared by writing 1 to it. The interrupt line is high while that flag and the enable are both set. A separate divider register sets the serial clock rate.

Top module: `bufspi_master`

## Requirements
- R1: After reset, the control word reads 0x0000, the divider reads 2, `spi_cs_n` is 1, `spi_sck` is 0 and `irq` is 0.
- R2: The buffer occupies byte addresses 0 to 1023. Buffer bytes are read and written on bits [7:0] of the data bus. The control word is at address 0x400 and the divider at 0x402. Reads return data one cycle after `bus_re`. The control word reads as {busy[15], release[14], enable[13], done[12], 2'b00, length[9:0]}.
- R3: A control write with bit 15 set starts a transfer of length[9:0] bytes. The bytes are taken from buffer offsets 0, 1, 2 and so on, and each is shifted out on `spi_mosi` MSB first, stable on every rising edge of `spi_sck`.
- R4: The byte sampled from `spi_miso` on the eight rising edges of byte k is written to buffer offset k.
- R5: A start with length field 0 transfers 1024 bytes.
- R6: When a transfer finishes, bit 12 reads 1 and bit 15 reads 0. Bit 12 is cleared by a control write with bit 12 set, and also by a new start.
- R7: `irq` is 1 exactly while bit 12 and bit 13 are both 1.
- R8: If bit 14 was 0 in the start command, `spi_cs_n` stays 0 after the transfer, so the next transfer continues the same frame. If bit 14 was 1, `spi_cs_n` goes to 1 when the transfer ends.
- R9: A control write with bit 14 set and bit 15 clear, made while idle, drives `spi_cs_n` to 1.
- R10: `spi_sck` is low whenever `spi_cs_n` is high. Each high phase of `spi_sck` lasts max(divider,1)+1 system clocks, and so does each low phase inside a byte.
- R11: While a transfer is running, bit 15 reads 1, and writes to the buffer, the control word and the divider are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_addr | input | 11 | Host byte address |
| bus_wdata | input | 16 | Host write data (buffer uses [7:0]) |
| bus_rdata | output | 16 | Host read data, valid one cycle after bus_re |
| irq | output | 1 | Completion interrupt |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The properties assume that the host never issues a read and a write in the same cycle. They also assume that the engine's buffer writes and the host's buffer writes never coincide. The block ensures the second by refusing host buffer writes while busy, and the bench drives one strobe at a time. The bench's serial slave is passive: it changes `spi_miso` only on falling edges of `spi_sck` or of `spi_cs_n`, which matches the mode 0 timing that the rising-edge sampling relies on. The bench makes its writes during a transfer only after it has seen busy read back as 1, so the test of the ignored-write rule is not timing dependent.

// File: rtl/bufspi_pkg.sv
package bufspi_pkg;
  localparam int CTL_DONE = 12;
  localparam int CTL_IE   = 13;
  localparam int CTL_REL  = 14;
  localparam int CTL_GO   = 15;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_FETCH,
    ENG_LOAD,
    ENG_LO,
    ENG_HI,
    ENG_STORE,
    ENG_END
  } eng_state_t;
endpackage

// File: rtl/bufspi_ram.sv
module bufspi_ram #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] a_addr,
  output logic [7:0]    a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [7:0]    b_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/bufspi_tick.sv
module bufspi_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CW = DIV_W + 1;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_cnt;

  // a zero divider behaves like one
  assign last_cnt = (div == '0) ? CW'(1) : {1'b0, div};
  assign tick     = run && (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/bufspi_engine.sv
module bufspi_engine
  import bufspi_pkg::*;
#(
  parameter int AW    = 10,
  parameter int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] total,
  input  logic             tick,
  input  logic [7:0]       rd_data,
  input  logic             miso,
  output logic [AW-1:0]    addr,
  output logic             we,
  output logic [7:0]       wdata,
  output logic             run,
  output logic             sck,
  output logic             mosi,
  output logic             fin
);
  eng_state_t       st;
  logic [CNT_W-1:0] idx;
  logic [2:0]       bitc;
  logic [7:0]       sh;
  logic [7:0]       rx;

  assign addr  = idx[AW-1:0];
  assign we    = (st == ENG_STORE);
  assign wdata = rx;
  assign run   = (st == ENG_LO) || (st == ENG_HI);
  assign fin   = (st == ENG_END);
  assign mosi  = sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ENG_IDLE;
      idx  <= '0;
      bitc <= '0;
      sh   <= '0;
      rx   <= '0;
      sck  <= 1'b0;
    end else begin
      unique case (st)
        ENG_IDLE: if (go) begin
          idx <= '0;
          st  <= ENG_FETCH;
        end
        ENG_FETCH: st <= ENG_LOAD;
        ENG_LOAD: begin
          sh   <= rd_data;
          bitc <= '0;
          st   <= ENG_LO;
        end
        ENG_LO: if (tick) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
          st  <= ENG_HI;
        end
        ENG_HI: if (tick) begin
          sck <= 1'b0;
          sh  <= {sh[6:0], 1'b0};
          if (bitc == 3'd7) st <= ENG_STORE;
          else begin
            bitc <= bitc + 3'd1;
            st   <= ENG_LO;
          end
        end
        ENG_STORE: begin
          if (idx == total - CNT_W'(1)) st <= ENG_END;
          else begin
            idx <= idx + CNT_W'(1);
            st  <= ENG_FETCH;
          end
        end
        ENG_END: st <= ENG_IDLE;
        default: st <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bufspi_master.sv
module bufspi_master
  import bufspi_pkg::*;
#(
  parameter int BUF_BYTES = 1024,
  parameter int ADDR_W    = $clog2(BUF_BYTES) + 1,
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  localparam int AW    = $clog2(BUF_BYTES);
  localparam int LEN_W = AW;
  localparam int CNT_W = AW + 1;
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(BUF_BYTES);
  localparam logic [ADDR_W-1:0] DIV_ADDR = ADDR_W'(BUF_BYTES + 2);

  logic [LEN_W-1:0] len_q;
  logic             ie_q, rel_q, done_q, busy_q, cs_n_q, irq_q;
  logic [DIV_W-1:0] div_q;
  logic [15:0]      reg_rd_q;
  logic             rd_buf_q;

  logic is_buf, is_ctl, is_div;
  logic host_buf_we, ctl_wr, go;
  logic done_n, ie_n;
  logic [CNT_W-1:0] total;
  logic [15:0] ctl_view;
  logic [15:0] ctl_wmask;
  logic unused_wbits;

  logic [AW-1:0] eng_addr;
  logic          eng_we, eng_run, eng_fin, tick;
  logic [7:0]    eng_wdata, a_rdata, b_rdata;

  assign is_buf      = (bus_addr[ADDR_W-1:AW] == '0);
  assign is_ctl      = (bus_addr == CTL_ADDR);
  assign is_div      = (bus_addr == DIV_ADDR);
  assign host_buf_we = bus_we && is_buf && !busy_q;
  assign ctl_wr      = bus_we && is_ctl && !busy_q;
  assign go          = ctl_wr && bus_wdata[CTL_GO];
  assign total       = {len_q == '0, len_q};

  generate
    if (LEN_W < 12) begin : g_gap
      assign ctl_view = {busy_q, rel_q, ie_q, done_q, {(12-LEN_W){1'b0}}, len_q};
    end else begin : g_nogap
      assign ctl_view = {busy_q, rel_q, ie_q, done_q, len_q[11:0]};
    end
  endgenerate
  assign ctl_wmask    = 16'hF000 | 16'((1 << LEN_W) - 1);
  assign unused_wbits = &(bus_wdata | ctl_wmask);

  always_comb begin
    done_n = done_q;
    ie_n   = ie_q;
    if (ctl_wr) begin
      ie_n = bus_wdata[CTL_IE];
      if (bus_wdata[CTL_DONE] || bus_wdata[CTL_GO]) done_n = 1'b0;
    end
    if (eng_fin) done_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= '0;
      ie_q     <= 1'b0;
      rel_q    <= 1'b0;
      done_q   <= 1'b0;
      busy_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      irq_q    <= 1'b0;
      div_q    <= DIV_W'(DIV_RESET);
      reg_rd_q <= '0;
      rd_buf_q <= 1'b0;
    end else begin
      done_q <= done_n;
      ie_q   <= ie_n;
      irq_q  <= done_n && ie_n;
      if (ctl_wr) begin
        len_q <= bus_wdata[LEN_W-1:0];
        rel_q <= bus_wdata[CTL_REL];
        if (bus_wdata[CTL_GO]) begin
          busy_q <= 1'b1;
          cs_n_q <= 1'b0;
        end else if (bus_wdata[CTL_REL]) begin
          cs_n_q <= 1'b1;
        end
      end
      if (bus_we && is_div && !busy_q) div_q <= bus_wdata[DIV_W-1:0];
      if (eng_fin) begin
        busy_q <= 1'b0;
        if (rel_q) cs_n_q <= 1'b1;
      end
      if (bus_re) begin
        rd_buf_q <= is_buf;
        if (is_ctl)      reg_rd_q <= ctl_view;
        else if (is_div) reg_rd_q <= 16'(div_q);
        else             reg_rd_q <= '0;
      end
    end
  end

  assign bus_rdata = rd_buf_q ? {8'h00, a_rdata} : reg_rd_q;
  assign irq       = irq_q;
  assign spi_cs_n  = cs_n_q;

  bufspi_ram #(.DEPTH(BUF_BYTES), .AW(AW)) i_ram (
    .clk    (clk),
    .we     (host_buf_we || eng_we),
    .waddr  (eng_we ? eng_addr : bus_addr[AW-1:0]),
    .wdata  (eng_we ? eng_wdata : bus_wdata[7:0]),
    .a_addr (bus_addr[AW-1:0]),
    .a_rdata(a_rdata),
    .b_addr (eng_addr),
    .b_rdata(b_rdata)
  );

  bufspi_tick #(.DIV_W(DIV_W)) i_tick (
    .clk (clk),
    .rst (rst),
    .run (eng_run),
    .div (div_q),
    .tick(tick)
  );

  bufspi_engine #(.AW(AW), .CNT_W(CNT_W)) i_eng (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .total  (total),
    .tick   (tick),
    .rd_data(b_rdata),
    .miso   (spi_miso),
    .addr   (eng_addr),
    .we     (eng_we),
    .wdata  (eng_wdata),
    .run    (eng_run),
    .sck    (spi_sck),
    .mosi   (spi_mosi),
    .fin    (eng_fin)
  );
endmodule

// File: rtl/bufspi_checker.sv
module bufspi_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             sck,
  input logic             irq,
  input logic             busy,
  input logic             done,
  input logic             ie,
  input logic [DIV_W-1:0] div
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sck); // R10
  AST_BUSY_HOLDS_CS: assert property (@(posedge clk) disable iff (rst) busy |-> !cs_n); // R8
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst) irq |-> (done && ie)); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> $past(busy)); // R6
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(div)); // R11
  AST_CS_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> !busy); // R9
endmodule

bind bufspi_master bufspi_checker #(.DIV_W(DIV_W)) i_chk (
  .clk (clk),
  .rst (rst),
  .cs_n(spi_cs_n),
  .sck (spi_sck),
  .irq (irq),
  .busy(busy_q),
  .done(done_q),
  .ie  (ie_q),
  .div (div_q)
);

// File: tb/test_bufspi_master.sv
`timescale 1ns/1ps
module test_bufspi_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, spi_sck, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  int checks = 0, failures = 0;
  int cycles = 0;
  int cur_div = 2;
  int hi_run = 0;

  // passive serial slave model
  int   gidx = 0;
  int   nb = 0, pbits = 0, frames = 0;
  logic [7:0] cap = '0;
  logic [7:0] captured [$];
  logic [7:0] txb [1024];

  always #2 clk = ~clk;

  bufspi_master i_bufspi_master (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  function automatic logic [7:0] slave_byte(int n);
    return 8'((n * 37 + 11) ^ (n >> 3));
  endfunction

  function automatic int exp_half(int d);
    return ((d == 0) ? 1 : d) + 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge spi_cs_n) begin
    nb = 0; pbits = 0; frames++;
    spi_miso = slave_byte(gidx)[7];
  end
  always @(posedge spi_sck) begin
    cap = {cap[6:0], spi_mosi};
    pbits++;
    if (pbits == 8) begin captured.push_back(cap); pbits = 0; end
  end
  always @(negedge spi_sck) begin
    nb++;
    if (nb == 8) begin nb = 0; gidx++; end
    spi_miso = slave_byte(gidx)[7 - nb];
  end

  // per-clock timing model of the serial clock
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (spi_cs_n && spi_sck) chk(1'b0, "R10 sck high with cs released", 1, 0);
      if (spi_sck) hi_run++;
      else if (hi_run > 0) begin
        chk(hi_run == exp_half(cur_div), "R10 sck high width", hi_run, exp_half(cur_div));
        hi_run = 0;
      end
    end
  end

  task automatic bus_write(int a, int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 11'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(int a, output int d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = 11'(a);
    @(negedge clk);
    bus_re = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic wait_idle();
    int v;
    for (int i = 0; i < 60000; i++) begin
      bus_read(11'h400, v);
      if (v[15] == 0) return;
    end
    chk(1'b0, "R11 busy never cleared", 1, 0);
  endtask

  task automatic run_xfer(int n, bit ie, bit rel, int seed, bit poke);
    int g0, c0, v, bad, first_a, first_e;
    for (int k = 0; k < n; k++) begin
      txb[k] = 8'(k * 13 + seed);
      bus_write(k, txb[k]);
    end
    g0 = gidx;
    c0 = captured.size();
    bus_write(11'h400, (1 << 15) | (int'(rel) << 14) | (int'(ie) << 13) | (n & 1023));
    if (poke) begin
      bus_read(11'h400, v);
      chk(v[15] == 1, "R11 busy bit during transfer", v[15], 1);
      bus_write(n - 1, 8'hAA);
      bus_write(11'h400, (1 << 15) | 1);
      bus_write(11'h402, 9);
    end
    wait_idle();
    chk(captured.size() == c0 + n, "R3 byte count on wire", captured.size() - c0, n);
    bad = 0; first_a = 0; first_e = 0;
    for (int k = 0; k < n && (c0 + k) < captured.size(); k++)
      if (captured[c0 + k] !== txb[k]) begin
        if (bad == 0) begin first_a = captured[c0 + k]; first_e = txb[k]; end
        bad++;
      end
    chk(bad == 0, poke ? "R11 MOSI bytes unaffected by busy writes" : "R3 MOSI bytes", first_a, first_e);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      bus_read(k, v);
      if (v != int'(slave_byte(g0 + k))) begin
        if (bad == 0) begin first_a = v; first_e = slave_byte(g0 + k); end
        bad++;
      end
    end
    chk(bad == 0, "R4 buffer holds received bytes", first_a, first_e);
    bus_read(11'h400, v);
    chk(v[12] == 1 && v[15] == 0, "R6 done set and busy clear", v[15:12], 4'b0001 | (v[14:13] << 1));
    chk(irq == ie, "R7 irq follows enable", irq, ie);
  endtask

  initial begin
    int v, f0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1 && spi_sck == 0 && irq == 0, "R1 pins after reset",
        {spi_cs_n, spi_sck, irq}, 3'b100);
    bus_read(11'h400, v);
    chk(v == 0, "R1 control after reset", v, 0);
    bus_read(11'h402, v);
    chk(v == 2, "R1 divider after reset", v, 2);

    // basic transfer, released, interrupt enabled
    run_xfer(4, 1'b1, 1'b1, 5, 1'b0);
    bus_read(11'h400, v);
    chk(v == 16'h7004, "R2 control word layout", v, 16'h7004);
    chk(spi_cs_n == 1, "R8 cs released after last", spi_cs_n, 1);
    bus_write(11'h400, 16'h7004);
    bus_read(11'h400, v);
    chk(v == 16'h6004, "R6 write one clears done", v, 16'h6004);
    chk(irq == 0, "R7 irq low after clear", irq, 0);

    // interrupt disabled
    run_xfer(2, 1'b0, 1'b1, 77, 1'b0);

    // chained fragments in one frame
    f0 = frames;
    run_xfer(3, 1'b1, 1'b0, 21, 1'b0);
    chk(spi_cs_n == 0, "R8 cs held between fragments", spi_cs_n, 0);
    run_xfer(2, 1'b1, 1'b1, 99, 1'b0);
    chk(spi_cs_n == 1 && frames == f0 + 1, "R8 one frame for two fragments",
        frames - f0, 1);

    // forced release
    run_xfer(2, 1'b0, 1'b0, 3, 1'b0);
    chk(spi_cs_n == 0, "R9 cs held before release", spi_cs_n, 0);
    bus_write(11'h400, 16'h4000);
    chk(spi_cs_n == 1, "R9 forced release", spi_cs_n, 1);

    // slower clock
    bus_write(11'h402, 5);
    cur_div = 5;
    bus_read(11'h402, v);
    chk(v == 5, "R2 divider readback", v, 5);
    run_xfer(3, 1'b1, 1'b1, 40, 1'b0);

    // writes while busy are ignored
    bus_write(11'h402, 2);
    cur_div = 2;
    run_xfer(6, 1'b1, 1'b1, 60, 1'b1);
    bus_read(11'h402, v);
    chk(v == 2, "R11 divider write ignored while busy", v, 2);

    // full buffer with length field zero, zero divider
    bus_write(11'h402, 0);
    cur_div = 0;
    run_xfer(1024, 1'b1, 1'b1, 7, 1'b0);
    chk(1, "R5 full buffer transfer completed", 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule